// File: doc/BRIEF.md
# Fan PWM Controller With Register Port

This block generates a single pulse-width-modulated drive signal for a two-wire fan. Software controls it through two word-aligned 32-bit registers on a simple request/response port. The control word holds a run bit, a mode bit and an 8-bit duty value. The speed word holds a 16-bit fan speed ceiling that the block stores for software and does not use itself.

The output period is fixed at 40 ms. The number of clock cycles in one period comes from a clock-frequency parameter. Within each period the output is high for `floor(duty * PERIOD_CYC / 255)` cycles, measured from the start of the period. A duty of 255 keeps the output high and a duty of 0 keeps it low. The output is always active high.

Clearing the run bit drives the output low and returns the period counter to zero, so the next enable starts a fresh period. A duty change written while the block runs is applied at once, and the counter is not restarted.

Top module: `fanpwm_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000_0000, the speed word reads 0x0000_0FA0 (4000), `pwm_o` is 0, and `req_ready` is 0 while reset is held.
- R2: The control word is at offset 0x0. Bit 0 is run, bit 1 is mode and bits 23:16 are duty. Every other bit reads 0 and ignores writes.
- R3: The speed word is at offset 0x4. Bits 15:0 hold the speed ceiling and bits 31:16 read 0.
- R4: A write changes only the bytes whose `req_wstrb` bit is 1. Strobe bit n covers data bits 8n+7:8n.
- R5: A read from offset 0x8 or 0xC returns 0, and a write to either offset changes no register.
- R6: While the block runs, the output repeats with a period of PERIOD_CYC = CLK_HZ*40/1000 cycles. Each period begins with `floor(duty*PERIOD_CYC/255)` high cycles, followed by low cycles for the rest of the period.
- R7: Duty 255 keeps the output high in every cycle of a running period, and duty 0 keeps it low.
- R8: After the run bit is written to 0, the output is low from the second cycle onward. After the run bit is written to 1, the output starts a new period at position zero, in the second cycle after the write.
- R9: With mode 1, the output stays low whatever the run bit and duty hold. Mode 0 selects two-wire operation.
- R10: A duty change written while running is used from the second cycle after the write, within the period already in progress. Every later period follows the new duty in full.
- R11: A read accepted in one cycle raises `rsp_valid` with its data in the next cycle. `rsp_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block accepts requests (high once out of reset) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte enables for a write |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | 32 | Read data |
| pwm_o | output | 1 | Fan drive output, active high |

## Verification
The two functions that can meet in one cycle are a register write that changes duty or run, and the period counter's compare at the same edge. The bench provokes this in two ways. It rewrites the duty a known number of samples into a running period. It also writes the run bit while the counter is part-way through a period. In both cases it tracks the expected sample index from the write edge and judges every following output sample against the compare result for that index. This shows which duty value, or which run state, each edge used.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned STRB_W    = REG_W / 8;
  localparam int unsigned DUTY_W    = 8;
  localparam int unsigned SPEED_W   = 16;
  localparam int unsigned PERIOD_US = 40000;

  // bit positions of the control word fields
  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned MODE_BIT  = 1;
  localparam int unsigned DUTY_LSB  = 16;
  localparam int unsigned DUTY_BYTE = DUTY_LSB / 8;

  // word indices in the register window
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_SPEED = 1;

  localparam logic [SPEED_W-1:0] SPEED_RST = 16'd4000;

  typedef enum logic {
    MODE_TWO_WIRE  = 1'b0,
    MODE_FOUR_WIRE = 1'b1
  } fan_mode_e;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    fan_mode_e         mode;
    logic              run;
  } ctrl_t;

endpackage

// File: rtl/fanpwm_rst_sync.sv
module fanpwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
  import fanpwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_fire,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [REG_W-1:0]   req_wdata,
  input  logic [STRB_W-1:0]  req_wstrb,
  output logic               rsp_valid,
  output logic [REG_W-1:0]   rsp_rdata,
  output ctrl_t              ctrl,
  output logic [SPEED_W-1:0] speed
);

  localparam int unsigned IDX_W       = ADDR_W - 2;
  localparam int unsigned SPEED_BYTES = SPEED_W / 8;

  logic [IDX_W-1:0] word_idx;
  logic             hit_ctrl;
  logic             hit_speed;
  logic             wr_ctrl;
  logic             wr_speed;
  logic             rd_fire;

  ctrl_t               ctrl_q, ctrl_d;
  logic [SPEED_W-1:0]  speed_q, speed_d;
  logic                rsp_valid_q, rsp_valid_d;
  logic [REG_W-1:0]    rdata_q, rdata_d;
  logic [REG_W-1:0]    ctrl_word;
  logic [REG_W-1:0]    speed_word;

  assign word_idx  = req_addr[ADDR_W-1:2];
  assign hit_ctrl  = (word_idx == IDX_W'(IDX_CTRL));
  assign hit_speed = (word_idx == IDX_W'(IDX_SPEED));
  assign wr_ctrl   = req_fire && req_write && hit_ctrl;
  assign wr_speed  = req_fire && req_write && hit_speed;
  assign rd_fire   = req_fire && !req_write;

  // register images as seen by software
  always_comb begin
    ctrl_word                      = '0;
    ctrl_word[RUN_BIT]             = ctrl_q.run;
    ctrl_word[MODE_BIT]            = ctrl_q.mode;
    ctrl_word[DUTY_LSB +: DUTY_W]  = ctrl_q.duty;
    speed_word                     = '0;
    speed_word[SPEED_W-1:0]        = speed_q;
  end

  // next state
  always_comb begin
    ctrl_d  = ctrl_q;
    speed_d = speed_q;
    if (wr_ctrl) begin
      if (req_wstrb[0]) begin
        ctrl_d.run  = req_wdata[RUN_BIT];
        ctrl_d.mode = fan_mode_e'(req_wdata[MODE_BIT]);
      end
      if (req_wstrb[DUTY_BYTE]) begin
        ctrl_d.duty = req_wdata[DUTY_LSB +: DUTY_W];
      end
    end
    if (wr_speed) begin
      for (int b = 0; b < SPEED_BYTES; b++) begin
        if (req_wstrb[b]) begin
          speed_d[b*8 +: 8] = req_wdata[b*8 +: 8];
        end
      end
    end
    rsp_valid_d = rd_fire;
    rdata_d     = '0;
    if (rd_fire) begin
      if (hit_ctrl) begin
        rdata_d = ctrl_word;
      end else if (hit_speed) begin
        rdata_d = speed_word;
      end
    end
  end

  // state registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{duty: '0, mode: MODE_TWO_WIRE, run: 1'b0};
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q <= SPEED_RST;
    end else if (wr_speed) begin
      speed_q <= speed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rdata_q     <= rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_q;
  assign ctrl      = ctrl_q;
  assign speed     = speed_q;

endmodule

// File: rtl/fanpwm_duty_scale.sv
module fanpwm_duty_scale
  import fanpwm_pkg::*;
#(
  parameter longint unsigned PERIOD_CYC = 1020,
  parameter int unsigned     CNT_W      = 10
) (
  input  logic [DUTY_W-1:0] duty,
  output logic [CNT_W-1:0]  thr
);

  localparam int unsigned       PROD_W  = CNT_W + DUTY_W;
  localparam logic [PROD_W-1:0] PER_EXT = PROD_W'(PERIOD_CYC);
  localparam logic [PROD_W-1:0] FULL    = PROD_W'((1 << DUTY_W) - 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  // high-time length in cycles; full scale maps onto the whole period
  assign prod = PROD_W'(duty) * PER_EXT;
  assign quot = prod / FULL;
  assign thr  = quot[CNT_W-1:0];

endmodule

// File: rtl/fanpwm_period_gen.sv
module fanpwm_period_gen #(
  parameter longint unsigned PERIOD_CYC = 1020,
  parameter int unsigned     CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pwm_q, pwm_d;

  always_comb begin
    if (!run) begin
      cnt_d = '0;
      pwm_d = 1'b0;
    end else begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      pwm_d = (cnt_q < thr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
    end
  end

  assign cnt = cnt_q;
  assign pwm = pwm_q;

endmodule

// File: rtl/fanpwm_ctrl.sv
module fanpwm_ctrl
  import fanpwm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_wstrb,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              pwm_o
);

  localparam longint unsigned PERIOD_CYC =
    (longint'(CLK_HZ) * longint'(PERIOD_US)) / 64'd1_000_000;
  localparam int unsigned CNT_W = $clog2(PERIOD_CYC + 1);

  logic               rst_sync_n;
  logic               req_fire;
  ctrl_t              ctrl;
  logic [SPEED_W-1:0] speed;
  logic               run;
  logic [CNT_W-1:0]   thr;
  logic [CNT_W-1:0]   cnt;

  fanpwm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign req_ready = rst_sync_n;
  assign req_fire  = req_valid && req_ready;

  fanpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_fire  (req_fire),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_wstrb (req_wstrb),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ctrl      (ctrl),
    .speed     (speed)
  );

  // only two-wire operation drives the fan
  assign run = ctrl.run && (ctrl.mode == MODE_TWO_WIRE);

  fanpwm_duty_scale #(.PERIOD_CYC(PERIOD_CYC), .CNT_W(CNT_W)) u_scale (
    .duty (ctrl.duty),
    .thr  (thr)
  );

  fanpwm_period_gen #(.PERIOD_CYC(PERIOD_CYC), .CNT_W(CNT_W)) u_gen (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .thr   (thr),
    .cnt   (cnt),
    .pwm   (pwm_o)
  );

endmodule

// File: rtl/fanpwm_sva.sv
module fanpwm_sva #(
  parameter longint unsigned PERIOD_CYC = 1020,
  parameter int unsigned     CNT_W      = 10
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic             run,
  input logic [7:0]       duty,
  input logic [CNT_W-1:0] cnt,
  input logic             pwm
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt <= LAST);

  p_cnt_wrap_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && cnt == LAST) |=> (cnt == '0));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && cnt != LAST) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run |=> (!pwm && cnt == '0));

  p_full_high_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && duty == 8'hFF) |=> pwm);

  p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (duty == 8'h00) |=> !pwm);

  p_rsp_after_rd_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  p_rsp_only_rd_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);

  p_rdata_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> (rsp_rdata[31:24] == 8'h00));

endmodule

bind fanpwm_ctrl fanpwm_sva #(.PERIOD_CYC(PERIOD_CYC), .CNT_W(CNT_W)) u_sva (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .run        (run),
  .duty       (ctrl.duty),
  .cnt        (cnt),
  .pwm        (pwm_o)
);

// File: tb/fanpwm_ctrl_test.sv
`timescale 1ns/1ps
module fanpwm_ctrl_test;

  localparam int unsigned CLK_HZ = 25_500;
  localparam int unsigned ADDR_W = 4;
  localparam int          P      = CLK_HZ * 40 / 1000;   // 1020 cycles
  localparam int          NVEC   = 8;

  // {waddr, wstrb, wdata, raddr, expected read}
  localparam logic [75:0] VEC [NVEC] = '{
    {4'h0, 4'hF, 32'hFFFF_FFFF, 4'h0, 32'h00FF_0003},
    {4'h0, 4'h4, 32'h0012_0000, 4'h0, 32'h0012_0003},
    {4'h0, 4'h1, 32'hFFFF_FF00, 4'h0, 32'h0012_0000},
    {4'h4, 4'hF, 32'hABCD_1234, 4'h4, 32'h0000_1234},
    {4'h4, 4'h2, 32'h0000_5600, 4'h4, 32'h0000_5634},
    {4'h8, 4'hF, 32'hFFFF_FFFF, 4'h8, 32'h0000_0000},
    {4'hC, 4'hF, 32'hFFFF_FFFF, 4'h0, 32'h0012_0000},
    {4'hC, 4'hF, 32'hFFFF_FFFF, 4'h4, 32'h0000_5634}
  };

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic [3:0]        req_wstrb;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              pwm_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fanpwm_ctrl #(.CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_wstrb (req_wstrb),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .pwm_o     (pwm_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [3:0] s,
                           input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wstrb = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wstrb = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d,
                          output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  // sample n cycles; sample i expected high when ((base+i) mod P) < thr
  task automatic pattern(input int n, input int thr, input int base, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o !== (((base + i) % P) < thr)) bad++;
    end
  endtask

  task automatic start_run(input logic [7:0] duty);
    bus_write(4'h0, 4'hF, 32'h0);
    repeat (2) @(negedge clk);
    bus_write(4'h0, 4'hF, {8'h00, duty, 16'h0001});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    int          bad;
    int          low_cnt;

    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_wstrb = '0;
    repeat (4) @(negedge clk);
    // R1: ready low and output low while reset is held
    check(req_ready == 1'b0 && pwm_o == 1'b0, "R1 reset outputs", {30'd0, req_ready, pwm_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(4'h0, rd, rv);
    check(rv && rd == 32'h0, "R1 control reset value", rd, 32'h0);
    bus_read(4'h4, rd, rv);
    check(rv && rd == 32'h0000_0FA0, "R1 speed reset value", rd, 32'h0FA0);

    // R2 R3 R4 R5: register vector walk
    for (int k = 0; k < NVEC; k++) begin
      bus_write(VEC[k][75:72], VEC[k][71:68], VEC[k][67:36]);
      bus_read(VEC[k][35:32], rd, rv);
      check(rv && rd == VEC[k][31:0], $sformatf("R2/R3/R4/R5 vector %0d", k),
            rd, VEC[k][31:0]);
    end

    // R11: rsp_valid low in the cycle after the response
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 rsp_valid drops", {31'd0, rsp_valid}, 0);

    // R7: duty 0 never high over more than a period
    start_run(8'd0);
    pattern(P + 1, 0, 0, bad);
    check(bad == 0, "R7 duty 0 low", bad, 0);

    // R6 R8: fresh period start and exact high length
    start_run(8'd1);
    pattern(P + 1, 4, 0, bad);
    check(bad == 0, "R6 duty 1 pattern", bad, 0);
    start_run(8'd128);
    pattern(P + 1, 512, 0, bad);
    check(bad == 0, "R6 duty 128 pattern", bad, 0);
    start_run(8'd64);
    pattern(300, 256, 0, bad);
    // R8: restart mid-period must begin again at position zero
    start_run(8'd200);
    pattern(P + 1, 800, 0, bad);
    check(bad == 0, "R8 restart from mid-period duty 200", bad, 0);

    // R7: duty 255 high throughout
    start_run(8'd255);
    pattern(P + 1, P, 0, bad);
    check(bad == 0, "R7 duty 255 high", bad, 0);

    // R8: clearing the run bit drives low from the second cycle
    bus_write(4'h0, 4'h1, 32'h0);
    low_cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pwm_o == 1'b0) low_cnt++;
    end
    check(low_cnt == 50, "R8 disable forces low", low_cnt, 50);

    // R9: mode 1 gives no output even with run and full duty
    bus_write(4'h0, 4'hF, 32'h00FF_0003);
    @(negedge clk);
    low_cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pwm_o == 1'b0) low_cnt++;
    end
    check(low_cnt == 200, "R9 mode 1 low", low_cnt, 200);

    // R10: duty change inside a running period
    start_run(8'd64);
    pattern(100, 256, 0, bad);
    check(bad == 0, "R10 before change", bad, 0);
    bus_write(4'h0, 4'h4, {8'h00, 8'd192, 16'h0000});
    pattern(P - 102, 768, 102, bad);
    check(bad == 0, "R10 same period uses new duty", bad, 0);
    pattern(P, 768, 0, bad);
    check(bad == 0, "R10 next period new duty", bad, 0);

    // R11: read response timing and no response after write
    bus_read(4'h0, rd, rv);
    check(rv && rd == 32'h00C0_0001, "R11 read after duty change", rd, 32'h00C0_0001);
    bus_write(4'h4, 4'hF, 32'h1);
    check(rsp_valid == 1'b0, "R11 no response to write", {31'd0, rsp_valid}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule